// File: doc/BRIEF.md
# Multi-Domain Clock Stop Controller

This block produces several groups of clock outputs from one fast input clock and gates them for power management. It drives four processor clocks, seven peripheral clocks at half the processor rate (one of them free-running), twelve memory clocks at the processor rate, and three reference clocks from a separate divider. Every output is a registered level, and the input clock is treated as an ideal digital clock. Oscillator, PLL, drive strength and serial configuration are not modelled. The processor clock toggles on every fast-clock edge, so it runs at half the fast-clock frequency.

Three power-management controls share pins with memory clock outputs 5, 6 and 7. The controls are power-down, processor stop and peripheral stop. A static mode strap decides whether those three pins carry control inputs or drive memory clocks. An output-enable input can silence everything. Each control passes through a two-flop synchronizer. A gate then changes state only at the start of its group's low phase, so every high pulse that leaves the block has its full nominal width. The internal divider phases keep running while outputs are stopped. Released peripheral clocks therefore come back aligned with the free-running one.

Top module: `clkstop_top`

## Requirements
- R1: Each processor output and each memory output is high for exactly one fast-clock cycle and low for one, so it runs at half the fast-clock frequency.
- R2: Each peripheral output is high for two fast-clock cycles and low for two. Its rising edges coincide with rising edges of the processor outputs.
- R3: Each reference output is high for REF_HALF fast-clock cycles and low for REF_HALF (default 3). Processor stop and peripheral stop do not affect it.
- R4: With the mode strap high, all twelve memory pins drive clocks, every memory pad enable is 1, and the shared-pin inputs have no effect.
- R5: With the mode strap low, memory pads 5, 6 and 7 have their pad enable at 0 and their clock value at 0. shared_pin_i[0] (pad 5) is power-down, shared_pin_i[1] (pad 6) is processor stop and shared_pin_i[2] (pad 7) is peripheral stop, all active high.
- R6: While processor stop is asserted, all processor outputs are low within 8 fast-clock cycles. Peripheral, memory and reference outputs keep running.
- R7: While peripheral stop is asserted, every peripheral output except index FREE_IDX (default 0) is low within 8 cycles. The free-running member keeps toggling.
- R8: While power-down is asserted, every output is low, including the free-running peripheral, memory and reference outputs. This holds within 2*REF_HALF+2 cycles of the synchronized assertion.
- R9: While output enable is low, every clock output is low, whatever the stop controls are.
- R10: Every high pulse on every output has its full nominal width, for any timing of control changes.
- R11: After peripheral stop is released, every gated peripheral output equals the free-running member on every cycle.
- R12: While the synchronous active-low reset is asserted, every clock output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | fast input clock |
| rst_ni | input | 1 | synchronous active-low reset |
| mode_i | input | 1 | strap: 1 = all memory pins drive clocks, 0 = pads 5..7 are control inputs |
| oe_i | input | 1 | output enable, low silences every output |
| shared_pin_i | input | 3 | values read from memory pads 5, 6, 7 (power-down, processor stop, peripheral stop) |
| cpu_clk_o | output | N_CPU | processor clocks |
| pci_clk_o | output | N_PCI | peripheral clocks, index FREE_IDX free-running |
| mem_clk_o | output | N_MEM | memory clock pad values |
| mem_oe_o | output | N_MEM | memory pad driver enables |
| ref_clk_o | output | N_REF | reference clocks |

## Verification
The hardest case to reach from the ports is a control edge that lands just before a group's low-phase boundary. That is where a careless gate would clip a pulse. A monitor measures every high pulse on all 26 outputs. A churn scenario toggles the three shared-pin controls and output enable from a pseudo-random sequence, with hold times of one to five cycles. This walks the control edges across every phase of the processor, peripheral and reference dividers. Directed scenarios then hold each control long enough to count rising edges per output in windows whose length is a multiple of every period. Release alignment is checked cycle by cycle against the free-running peripheral output.

// File: rtl/clkstop_pkg.sv
// Shared types for the clock stop controller.
// Assumes: controls are active high except output enable.
package clkstop_pkg;
    typedef struct packed {
        logic oe;        // output enable, high = run
        logic pd;        // power-down, high = all silent
        logic cpu_stop;  // processor group stop
        logic pci_stop;  // peripheral group stop (free member exempt)
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/clkstop_sync.sv
// Multi-stage synchronizer for control inputs into the fast clock domain.
// Assumes: inputs are asynchronous levels; STAGES >= 2; reset clears to 0.
module clkstop_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift each control one stage deeper per fast-clock edge.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= d_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/clkstop_phase.sv
// Free-running divider phases for the processor, peripheral and reference
// groups. Gives each group's next level and a strobe for the edge that
// starts its low phase. Assumes: REF_HALF >= 1. Phases never stop.
module clkstop_phase #(
    parameter int REF_HALF = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic cpu_lvl_d_o,
    output logic cpu_low_start_o,
    output logic pci_lvl_d_o,
    output logic pci_low_start_o,
    output logic ref_lvl_d_o,
    output logic ref_low_start_o
);
    localparam int RW = (REF_HALF > 1) ? $clog2(REF_HALF) : 1;
    localparam logic [RW-1:0] REF_LAST = RW'(REF_HALF - 1);

    logic [1:0]    ph_q;
    logic [1:0]    ph_d;
    logic          cpu_lvl_q, pci_lvl_q, ref_lvl_q;
    logic [RW-1:0] ref_cnt_q;
    logic          ref_wrap;

    assign ph_d        = ph_q + 2'd1;
    assign cpu_lvl_d_o = ~ph_d[0];
    assign pci_lvl_d_o = ~ph_d[1];
    assign ref_wrap    = (ref_cnt_q == REF_LAST);
    assign ref_lvl_d_o = ref_wrap ? ~ref_lvl_q : ref_lvl_q;

    assign cpu_low_start_o = cpu_lvl_q & ~cpu_lvl_d_o;
    assign pci_low_start_o = pci_lvl_q & ~pci_lvl_d_o;
    assign ref_low_start_o = ref_lvl_q & ~ref_lvl_d_o;

    // Advance the 2-bit phase shared by the processor and peripheral groups.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ph_q      <= 2'b11;
            cpu_lvl_q <= 1'b0;
            pci_lvl_q <= 1'b0;
        end else begin
            ph_q      <= ph_d;
            cpu_lvl_q <= cpu_lvl_d_o;
            pci_lvl_q <= pci_lvl_d_o;
        end
    end

    // Count reference half periods and toggle the reference level.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ref_cnt_q <= '0;
            ref_lvl_q <= 1'b0;
        end else begin
            ref_cnt_q <= ref_wrap ? '0 : ref_cnt_q + 1'b1;
            ref_lvl_q <= ref_lvl_d_o;
        end
    end

    // R2: a peripheral rising edge always lands on a processor rising edge.
    p_pci_rise_with_cpu_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pci_lvl_q) |-> $rose(cpu_lvl_q));
endmodule

// File: rtl/clkstop_gate.sv
// Gates one group of W clock outputs. The gate state is captured only at
// the start of the group's low phase, so no high pulse is ever clipped.
// EXEMPT marks members that ignore the group stop and obey only the global
// run (output enable and power-down). Assumes: lvl_d_i and low_start_i come
// from clkstop_phase.
module clkstop_gate #(
    parameter int           W      = 4,
    parameter logic [W-1:0] EXEMPT = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         lvl_d_i,
    input  logic         low_start_i,
    input  logic         run_all_i,
    input  logic         run_stop_i,
    output logic [W-1:0] clk_o
);
    logic gate_all_q;
    logic gate_stop_q;

    // Capture the run decisions only while the group is entering a low phase.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gate_all_q  <= 1'b0;
            gate_stop_q <= 1'b0;
        end else if (low_start_i) begin
            gate_all_q  <= run_all_i;
            gate_stop_q <= run_stop_i;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_out
        if (EXEMPT[i]) begin : g_free
            // Exempt member: follow the level unless globally silenced.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) clk_o[i] <= 1'b0;
                else         clk_o[i] <= lvl_d_i & gate_all_q;
            end
        end else begin : g_stoppable
            // Stoppable member: also obey the group stop gate.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) clk_o[i] <= 1'b0;
                else         clk_o[i] <= lvl_d_i & gate_all_q & gate_stop_q;
            end
        end
    end

    // R10: the global gate only moves while every output sits low.
    p_all_gate_moves_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_all_q != $past(gate_all_q)) |-> (clk_o == '0));

    // R10: the stop gate only moves while the stoppable outputs sit low.
    p_stop_gate_moves_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_stop_q != $past(gate_stop_q)) |-> ((clk_o & ~EXEMPT) == '0));

    // R6 / R7: a closed stop gate keeps every stoppable output low.
    p_stopped_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!gate_stop_q && !$past(gate_stop_q)) |-> ((clk_o & ~EXEMPT) == '0));
endmodule

// File: rtl/clkstop_top.sv
// Multi-domain clock stop controller. Builds processor, peripheral, memory
// and reference clock groups from one fast clock and gates them from
// synchronized stop, power-down and output-enable controls. In strap mode
// low, memory pads SHARE_BASE..SHARE_BASE+2 read the controls. Assumes:
// mode_i is static after reset; clk_i is an ideal clock.
module clkstop_top
    import clkstop_pkg::*;
#(
    parameter int N_CPU       = 4,
    parameter int N_PCI       = 7,
    parameter int N_MEM       = 12,
    parameter int N_REF       = 3,
    parameter int FREE_IDX    = 0,
    parameter int SHARE_BASE  = 5,
    parameter int REF_HALF    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mode_i,
    input  logic             oe_i,
    input  logic [2:0]       shared_pin_i,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic [N_MEM-1:0] mem_clk_o,
    output logic [N_MEM-1:0] mem_oe_o,
    output logic [N_REF-1:0] ref_clk_o
);
    localparam logic [N_PCI-1:0] PCI_FREE   = N_PCI'(1) << FREE_IDX;
    localparam logic [N_MEM-1:0] SHARE_MASK = N_MEM'(3'b111) << SHARE_BASE;

    ctl_t             ctl_raw;
    ctl_t             ctl_s;
    logic [CTL_W-1:0] ctl_s_vec;
    logic             run_all;
    logic             cpu_lvl_d, cpu_low_start;
    logic             pci_lvl_d, pci_low_start;
    logic             ref_lvl_d, ref_low_start;
    logic [N_MEM-1:0] mem_raw;

    // Select control sources: shared pads only count in strap mode low.
    always_comb begin
        ctl_raw.oe       = oe_i;
        ctl_raw.pd       = ~mode_i & shared_pin_i[0];
        ctl_raw.cpu_stop = ~mode_i & shared_pin_i[1];
        ctl_raw.pci_stop = ~mode_i & shared_pin_i[2];
    end

    clkstop_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (ctl_raw),
        .q_o    (ctl_s_vec)
    );

    assign ctl_s   = ctl_t'(ctl_s_vec);
    assign run_all = ctl_s.oe & ~ctl_s.pd;

    clkstop_phase #(.REF_HALF(REF_HALF)) u_phase (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .cpu_lvl_d_o     (cpu_lvl_d),
        .cpu_low_start_o (cpu_low_start),
        .pci_lvl_d_o     (pci_lvl_d),
        .pci_low_start_o (pci_low_start),
        .ref_lvl_d_o     (ref_lvl_d),
        .ref_low_start_o (ref_low_start)
    );

    clkstop_gate #(.W(N_CPU), .EXEMPT('0)) u_cpu_gate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lvl_d_i     (cpu_lvl_d),
        .low_start_i (cpu_low_start),
        .run_all_i   (run_all),
        .run_stop_i  (~ctl_s.cpu_stop),
        .clk_o       (cpu_clk_o)
    );

    clkstop_gate #(.W(N_PCI), .EXEMPT(PCI_FREE)) u_pci_gate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lvl_d_i     (pci_lvl_d),
        .low_start_i (pci_low_start),
        .run_all_i   (run_all),
        .run_stop_i  (~ctl_s.pci_stop),
        .clk_o       (pci_clk_o)
    );

    clkstop_gate #(.W(N_MEM), .EXEMPT('0)) u_mem_gate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lvl_d_i     (cpu_lvl_d),
        .low_start_i (cpu_low_start),
        .run_all_i   (run_all),
        .run_stop_i  (1'b1),
        .clk_o       (mem_raw)
    );

    clkstop_gate #(.W(N_REF), .EXEMPT('0)) u_ref_gate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lvl_d_i     (ref_lvl_d),
        .low_start_i (ref_low_start),
        .run_all_i   (run_all),
        .run_stop_i  (1'b1),
        .clk_o       (ref_clk_o)
    );

    // Release the shared pads to input duty when the strap is low.
    always_comb begin
        mem_oe_o  = mode_i ? '1 : ~SHARE_MASK;
        mem_clk_o = mem_raw & mem_oe_o;
    end

    // Checker counter: cycles that the synchronized power-down has been held.
    localparam int PD_LIMIT = 2 * REF_HALF + 2;
    localparam int PD_W     = $clog2(PD_LIMIT + 1);
    logic [PD_W-1:0] pd_hold_q;

    // Count power-down hold cycles, saturating at the settle limit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                          pd_hold_q <= '0;
        else if (!ctl_s.pd)                   pd_hold_q <= '0;
        else if (pd_hold_q != PD_W'(PD_LIMIT)) pd_hold_q <= pd_hold_q + 1'b1;
    end

    // R8: a settled power-down silences every group.
    p_pd_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pd_hold_q == PD_W'(PD_LIMIT)) |->
        (cpu_clk_o == '0 && pci_clk_o == '0 && mem_clk_o == '0 && ref_clk_o == '0));

    // R5: shared pads are released and quiet in strap mode low.
    p_shared_pads_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_i |-> ((mem_oe_o & SHARE_MASK) == '0 && (mem_clk_o & SHARE_MASK) == '0));

    // R4: strap mode high drives every memory pad.
    p_mode_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i |-> (mem_oe_o == '1));
endmodule

// File: tb/clkstop_top_bench.sv
module clkstop_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_CPU = 4, N_PCI = 7, N_MEM = 12, N_REF = 3;
    localparam int FREE_IDX = 0, REF_HALF = 3;
    localparam int NALL = N_CPU + N_PCI + N_MEM + N_REF;
    localparam int PCI0 = N_CPU, MEM0 = N_CPU + N_PCI, REF0 = N_CPU + N_PCI + N_MEM;
    localparam int WIN = 48;
    localparam int SETTLE = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             mode, oe;
    logic [2:0]       shared;
    logic [N_CPU-1:0] cpu;
    logic [N_PCI-1:0] pci;
    logic [N_MEM-1:0] mem, mem_oe;
    logic [N_REF-1:0] refc;
    logic [NALL-1:0]  all_v, prev_v;

    int n_checks = 0, n_fail = 0;
    int glitches = 0, pci_rises = 0, pci_misaligned = 0;
    int rise_cnt [NALL];
    int hi_len [NALL];

    always #(CLK_PERIOD/2) clk = ~clk;

    clkstop_top u_clkstop_top (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .oe_i(oe),
        .shared_pin_i(shared), .cpu_clk_o(cpu), .pci_clk_o(pci),
        .mem_clk_o(mem), .mem_oe_o(mem_oe), .ref_clk_o(refc)
    );

    assign all_v = {refc, mem, pci, cpu};

    function automatic int nominal(int i);
        if (i < PCI0) return 1;
        if (i < MEM0) return 2;
        if (i < REF0) return 1;
        return REF_HALF;
    endfunction

    // Pulse-width, rise-count and alignment monitor, sampled on falling edges.
    initial prev_v = '0;
    always @(negedge clk) begin
        for (int i = 0; i < NALL; i++) begin
            if (!rst_n) begin
                hi_len[i] = 0;
            end else if (all_v[i]) begin
                if (!prev_v[i]) rise_cnt[i] = rise_cnt[i] + 1;
                hi_len[i] = hi_len[i] + 1;
            end else if (hi_len[i] != 0) begin
                if (hi_len[i] != nominal(i)) begin
                    glitches = glitches + 1;
                    $display("pulse width error on output %0d: %0d cycles, nominal %0d",
                             i, hi_len[i], nominal(i));
                end
                hi_len[i] = 0;
            end
        end
        if (rst_n && all_v[PCI0+FREE_IDX] && !prev_v[PCI0+FREE_IDX]) begin
            pci_rises = pci_rises + 1;
            if (!(all_v[0] && !prev_v[0])) pci_misaligned = pci_misaligned + 1;
        end
        prev_v = all_v;
    end

    task automatic check_eq(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic count_window();
        for (int i = 0; i < NALL; i++) rise_cnt[i] = 0;
        pci_rises = 0;
        pci_misaligned = 0;
        tick(WIN);
    endtask

    // Check rise counts for a range of outputs against one expected value.
    task automatic check_range(string req, string grp, int lo, int hi, int exp);
        for (int i = lo; i < hi; i++)
            check_eq(req, $sformatf("%s output %0d rises", grp, i), rise_cnt[i], exp);
    endtask

    task automatic do_reset(logic m);
        @(posedge clk); #1;
        rst_n = 1'b0;
        mode  = m;
        oe    = 1'b1;
        shared = 3'b000;
        tick(4);
        check_eq("R12", "outputs during reset", int'(all_v), 0);
        rst_n = 1'b1;
        tick(SETTLE);
    endtask

    task automatic t_mode_high();
        do_reset(1'b1);
        shared = 3'b111;
        tick(SETTLE);
        count_window();
        check_range("R1", "cpu", 0, PCI0, WIN/2);
        check_range("R2", "pci", PCI0, MEM0, WIN/4);
        check_range("R4", "mem", MEM0, REF0, WIN/2);
        check_range("R3", "ref", REF0, NALL, WIN/(2*REF_HALF));
        check_eq("R4", "memory pad enables", int'(mem_oe), (1 << N_MEM) - 1);
        check_eq("R2", "pci rises off cpu rise", pci_misaligned, 0);
        check_eq("R2", "pci rises seen", pci_rises, WIN/4);
    endtask

    task automatic t_cpu_stop();
        do_reset(1'b0);
        check_eq("R5", "shared pad enables", int'(mem_oe[7:5]), 0);
        shared = 3'b010;
        tick(SETTLE);
        count_window();
        check_range("R6", "cpu", 0, PCI0, 0);
        check_range("R6", "pci", PCI0, MEM0, WIN/4);
        check_range("R6", "mem", MEM0, MEM0 + 5, WIN/2);
        check_range("R5", "shared mem", MEM0 + 5, MEM0 + 8, 0);
        check_range("R6", "mem", MEM0 + 8, REF0, WIN/2);
        check_range("R3", "ref", REF0, NALL, WIN/(2*REF_HALF));
        shared = 3'b000;
        tick(SETTLE);
        count_window();
        check_range("R6", "cpu after release", 0, PCI0, WIN/2);
    endtask

    task automatic t_pci_stop();
        do_reset(1'b0);
        shared = 3'b100;
        tick(SETTLE);
        count_window();
        for (int i = 0; i < N_PCI; i++)
            check_eq("R7", $sformatf("pci %0d rises", i), rise_cnt[PCI0+i],
                     (i == FREE_IDX) ? WIN/4 : 0);
        check_range("R7", "cpu", 0, PCI0, WIN/2);
        check_range("R3", "ref", REF0, NALL, WIN/(2*REF_HALF));
        shared = 3'b000;
        tick(SETTLE);
        for (int c = 0; c < 16; c++) begin
            check_eq("R11", "gated pci vs free member", int'(pci),
                     pci[FREE_IDX] ? (1 << N_PCI) - 1 : 0);
            tick(1);
        end
    endtask

    task automatic t_power_down();
        do_reset(1'b0);
        shared = 3'b001;
        tick(SETTLE);
        count_window();
        check_range("R8", "all", 0, NALL, 0);
        shared = 3'b000;
        tick(SETTLE);
        count_window();
        check_range("R8", "ref after release", REF0, NALL, WIN/(2*REF_HALF));
        check_range("R8", "cpu after release", 0, PCI0, WIN/2);
    endtask

    task automatic t_output_enable();
        do_reset(1'b1);
        oe = 1'b0;
        tick(SETTLE);
        count_window();
        check_range("R9", "all", 0, NALL, 0);
        oe = 1'b1;
        tick(SETTLE);
        count_window();
        check_range("R9", "pci after enable", PCI0, MEM0, WIN/4);
    endtask

    task automatic t_churn();
        logic [7:0] lfsr = 8'hA5;
        int glitch_before;
        do_reset(1'b0);
        glitch_before = glitches;
        for (int s = 0; s < 300; s++) begin
            lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            shared = lfsr[2:0];
            oe     = lfsr[7] | lfsr[6];
            tick(int'(lfsr[5:3]) % 5 + 1);
        end
        shared = 3'b000;
        oe     = 1'b1;
        tick(SETTLE);
        check_eq("R10", "clipped or stretched pulses", glitches - glitch_before, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 1'b1; oe = 1'b1; shared = 3'b000;
        for (int i = 0; i < NALL; i++) begin rise_cnt[i] = 0; hi_len[i] = 0; end
        t_mode_high();
        t_cpu_stop();
        t_pci_stop();
        t_power_down();
        t_output_enable();
        t_churn();
        check_eq("R10", "total clipped pulses", glitches, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule